// File: doc/BRIEF.md
# Two-Level Legacy Interrupt Aggregator and Serial-IRQ Router

This block gathers a set of level-sensitive legacy interrupt lines, plus a one-cycle "no response" error pulse, into a sticky first-level status word. Software masks that word and clears it through a 32-bit register port. The masked result, called the active set, leaves the block by one of two paths. A static mode pin selects the path. In routed mode, every source carries a small routing field that names one of several serial-IRQ output lines. A line is high while any active source is routed to it. In summary mode the routing fields are ignored. Any active source sets one bit of a second-level input word. A second-level status register latches that word, masked, and holds it until cleared. The single summary output is high while that second-level status is nonzero.

A global enable bit gates both paths. First-level status bits clear with write-one. A bit whose input is still high cannot be cleared this way. In routed mode, an auto-clear control bit makes a status bit drop on its own when its input falls. All outputs are registered. They are computed from the register values that take effect at the same clock edge, so a register write or an input edge shows at the outputs one clock after it is presented. The register port is a plain single-cycle control interface. A write takes effect at the clock edge, and the read data is a combinational view of the addressed register. There is no back-pressure: every access completes in the cycle it is presented.

Top module: `irq_agg_router`

## Requirements
- R1: After reset, every register reads zero and all serial-IRQ lines and the summary output are low. Register addresses are: 0 control (bit0 enable, bit1 auto-clear), 1 first-level mask, 2 first-level status, 3 routing word A, 4 routing word B, 5 polarity, 6 second-level mask, 7 second-level status, 8 registered input levels, 9 second-level input word. All other addresses read zero.
- R2: A rising input sets its status bit (status bit i for source i) and its bit in the input-level register. A falling input clears its input-level bit.
- R3: A write to status clears each bit written as one, except a bit whose input-level bit is high at that edge, which stays set.
- R4: In routed mode with auto-clear (control bit1) set, a falling input clears its status bit. Without auto-clear, the status bit stays set.
- R5: With enable (control bit0) clear, all serial-IRQ lines are low and the second-level input word is zero. First-level status still records events.
- R6: In routed mode, serial-IRQ line j is high exactly when some status bit i that is set and unmasked has routing field i equal to j. The fields are 2 bits each in the concatenation {word B, word A}, with field i at bits [2i+1:2i]. The error bit is bit 16 and uses word B bits [1:0].
- R7: In summary mode, all serial-IRQ lines stay low whatever the routing words hold. The second-level input word is 1 (bit0) while the active set is nonzero and the block is enabled, and 0 otherwise.
- R8: Second-level status ORs in (second-level input AND second-level mask) on every clock. Writing it clears the bits written as one, and a bit whose cause is still present sets again at once. The summary output is high exactly while second-level status is nonzero.
- R9: A no-response pulse sets first-level status bit 16.
- R10: A register write or input change is reflected at the outputs right after the clock edge that takes it in, and not before.
- R11: The polarity register stores and reads back all 32 bits and has no effect on status or outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| routed_mode | input | 1 | Static path select: 1 routed to serial-IRQ lines, 0 summary path |
| irq_in | input | NUM_SRC | Level-sensitive interrupt sources |
| noresp_pulse | input | 1 | No-response error event, one cycle |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| serirq_o | output | NUM_LINES | Serial-IRQ line requests |
| summary_o | output | 1 | Second-level summary interrupt |

## Verification
The bench builds the block with its defaults: 16 sources, four lines with 2-bit routing fields, an 8-bit second-level word and the summary bit at position 0. With these values the error bit is the 17th field, so it crosses into routing word B, and every one of the four lines can be reached from random routing words. The bench runs each mode from its own reset. In each mode, random register traffic, input toggling and error pulses are compared every cycle against a behavioural model. Directed steps cover write-one clearing of a held input, auto-clear on and off, disable, the polarity register and sticky re-latching of the second level.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  typedef enum logic [3:0] {
    RA_CTRL   = 4'd0,
    RA_MASK   = 4'd1,
    RA_STAT   = 4'd2,
    RA_ROUTEA = 4'd3,
    RA_ROUTEB = 4'd4,
    RA_POL    = 4'd5,
    RA_MASK2  = 4'd6,
    RA_STAT2  = 4'd7,
    RA_LEVEL  = 4'd8,
    RA_IN2    = 4'd9
  } reg_addr_e;

  localparam int unsigned CTRL_EN_BIT  = 0;
  localparam int unsigned CTRL_AC_BIT  = 1;
  localparam int unsigned CTRL_W       = 2;
endpackage

// File: rtl/irq_l1_status.sv
module irq_l1_status #(
  parameter int unsigned NUM_SRC = 16,
  localparam int unsigned STAT_W = NUM_SRC + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic               noresp,
  input  logic               routed,
  input  logic               auto_clr,
  input  logic               clr_we,
  input  logic [STAT_W-1:0]  clr_data,
  output logic [NUM_SRC-1:0] level_q,
  output logic [STAT_W-1:0]  stat_q,
  output logic [STAT_W-1:0]  stat_nxt
);
  logic [NUM_SRC-1:0] rise, fall;
  logic [STAT_W-1:0]  keep_held;

  assign rise      = irq_in & ~level_q;
  assign fall      = ~irq_in & level_q;
  assign keep_held = {1'b0, level_q};

  always_comb begin
    stat_nxt = stat_q;
    if (clr_we)
      stat_nxt = stat_nxt & ~(clr_data & ~keep_held);
    if (routed && auto_clr)
      stat_nxt = stat_nxt & ~{1'b0, fall};
    stat_nxt = stat_nxt | {noresp, rise};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      stat_q  <= '0;
    end else begin
      level_q <= irq_in;
      stat_q  <= stat_nxt;
    end
  end
endmodule

// File: rtl/irq_route_fanout.sv
module irq_route_fanout #(
  parameter int unsigned STAT_W    = 17,
  parameter int unsigned NUM_LINES = 4,
  localparam int unsigned ROUTE_W  = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int unsigned ROUTE_BITS = STAT_W * ROUTE_W
) (
  input  logic [STAT_W-1:0]     active,
  input  logic [ROUTE_BITS-1:0] route_flat,
  output logic [NUM_LINES-1:0]  line_hit
);
  for (genvar j = 0; j < NUM_LINES; j++) begin : g_line
    logic [STAT_W-1:0] sel;
    for (genvar i = 0; i < STAT_W; i++) begin : g_src
      assign sel[i] = (route_flat[i*ROUTE_W +: ROUTE_W] == ROUTE_W'(j));
    end
    assign line_hit[j] = |(active & sel);
  end
endmodule

// File: rtl/irq_l2_latch.sv
module irq_l2_latch #(
  parameter int unsigned L2_W    = 8,
  parameter int unsigned LPC_BIT = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lpc_req,
  input  logic [L2_W-1:0] mask2_nxt,
  input  logic            clr_we,
  input  logic [L2_W-1:0] clr_data,
  output logic [L2_W-1:0] in2_q,
  output logic [L2_W-1:0] stat2_q,
  output logic            summary_q
);
  logic [L2_W-1:0] in2_nxt, stat2_nxt;

  always_comb begin
    in2_nxt          = '0;
    in2_nxt[LPC_BIT] = lpc_req;
    stat2_nxt        = stat2_q;
    if (clr_we)
      stat2_nxt = stat2_nxt & ~clr_data;
    stat2_nxt = stat2_nxt | (in2_nxt & mask2_nxt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in2_q     <= '0;
      stat2_q   <= '0;
      summary_q <= 1'b0;
    end else begin
      in2_q     <= in2_nxt;
      stat2_q   <= stat2_nxt;
      summary_q <= |stat2_nxt;
    end
  end
endmodule

// File: rtl/irq_agg_router.sv
module irq_agg_router
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_SRC   = 16,
  parameter int unsigned NUM_LINES = 4,
  parameter int unsigned L2_W      = 8,
  parameter int unsigned LPC_BIT   = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 routed_mode,
  input  logic [NUM_SRC-1:0]   irq_in,
  input  logic                 noresp_pulse,
  input  logic                 reg_we,
  input  logic [3:0]           reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output logic [NUM_LINES-1:0] serirq_o,
  output logic                 summary_o
);
  localparam int unsigned STAT_W     = NUM_SRC + 1;
  localparam int unsigned ROUTE_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam int unsigned ROUTE_BITS = STAT_W * ROUTE_W;

  logic [CTRL_W-1:0]  ctrl_q, ctrl_nxt;
  logic [STAT_W-1:0]  mask_q, mask_nxt;
  logic [31:0]        routea_q, routea_nxt, routeb_q, routeb_nxt, pol_q;
  logic [L2_W-1:0]    mask2_q, mask2_nxt;
  logic [STAT_W-1:0]  stat_q, stat_nxt, active_nxt;
  logic [NUM_SRC-1:0] level_q;
  logic [L2_W-1:0]    in2_q, stat2_q;
  logic [63:0]        route_all;
  logic [NUM_LINES-1:0] line_hit, serirq_q;
  logic               en_nxt, lpc_req, summary_q;

  function automatic logic hit(input logic we, input logic [3:0] a, input reg_addr_e r);
    return we && (a == r);
  endfunction

  // next-state view of the software registers
  assign ctrl_nxt   = hit(reg_we, reg_addr, RA_CTRL)   ? reg_wdata[CTRL_W-1:0] : ctrl_q;
  assign mask_nxt   = hit(reg_we, reg_addr, RA_MASK)   ? reg_wdata[STAT_W-1:0] : mask_q;
  assign routea_nxt = hit(reg_we, reg_addr, RA_ROUTEA) ? reg_wdata : routea_q;
  assign routeb_nxt = hit(reg_we, reg_addr, RA_ROUTEB) ? reg_wdata : routeb_q;
  assign mask2_nxt  = hit(reg_we, reg_addr, RA_MASK2)  ? reg_wdata[L2_W-1:0] : mask2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      mask_q   <= '0;
      routea_q <= '0;
      routeb_q <= '0;
      pol_q    <= '0;
      mask2_q  <= '0;
    end else begin
      ctrl_q   <= ctrl_nxt;
      mask_q   <= mask_nxt;
      routea_q <= routea_nxt;
      routeb_q <= routeb_nxt;
      mask2_q  <= mask2_nxt;
      if (hit(reg_we, reg_addr, RA_POL))
        pol_q <= reg_wdata;
    end
  end

  irq_l1_status #(.NUM_SRC(NUM_SRC)) u_l1 (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_in   (irq_in),
    .noresp   (noresp_pulse),
    .routed   (routed_mode),
    .auto_clr (ctrl_q[CTRL_AC_BIT]),
    .clr_we   (hit(reg_we, reg_addr, RA_STAT)),
    .clr_data (reg_wdata[STAT_W-1:0]),
    .level_q  (level_q),
    .stat_q   (stat_q),
    .stat_nxt (stat_nxt)
  );

  assign active_nxt = stat_nxt & mask_nxt;
  assign en_nxt     = ctrl_nxt[CTRL_EN_BIT];
  assign route_all  = {routeb_nxt, routea_nxt};

  irq_route_fanout #(.STAT_W(STAT_W), .NUM_LINES(NUM_LINES)) u_fan (
    .active     (active_nxt),
    .route_flat (route_all[ROUTE_BITS-1:0]),
    .line_hit   (line_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) serirq_q <= '0;
    else        serirq_q <= (en_nxt && routed_mode) ? line_hit : '0;
  end

  assign lpc_req = en_nxt && !routed_mode && (|active_nxt);

  irq_l2_latch #(.L2_W(L2_W), .LPC_BIT(LPC_BIT)) u_l2 (
    .clk       (clk),
    .rst_n     (rst_n),
    .lpc_req   (lpc_req),
    .mask2_nxt (mask2_nxt),
    .clr_we    (hit(reg_we, reg_addr, RA_STAT2)),
    .clr_data  (reg_wdata[L2_W-1:0]),
    .in2_q     (in2_q),
    .stat2_q   (stat2_q),
    .summary_q (summary_q)
  );

  assign serirq_o  = serirq_q;
  assign summary_o = summary_q;

  always_comb begin
    case (reg_addr)
      RA_CTRL:   reg_rdata = 32'(ctrl_q);
      RA_MASK:   reg_rdata = 32'(mask_q);
      RA_STAT:   reg_rdata = 32'(stat_q);
      RA_ROUTEA: reg_rdata = routea_q;
      RA_ROUTEB: reg_rdata = routeb_q;
      RA_POL:    reg_rdata = pol_q;
      RA_MASK2:  reg_rdata = 32'(mask2_q);
      RA_STAT2:  reg_rdata = 32'(stat2_q);
      RA_LEVEL:  reg_rdata = 32'(level_q);
      RA_IN2:    reg_rdata = 32'(in2_q);
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_agg_router_chk.sv
module irq_agg_router_chk #(
  parameter int unsigned NUM_SRC   = 16,
  parameter int unsigned NUM_LINES = 4,
  parameter int unsigned L2_W      = 8,
  localparam int unsigned STAT_W   = NUM_SRC + 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 routed_mode,
  input logic [NUM_SRC-1:0]   irq_in,
  input logic                 noresp_pulse,
  input logic [NUM_LINES-1:0] serirq_o,
  input logic                 summary_o,
  input logic [1:0]           ctrl_q,
  input logic [STAT_W-1:0]    stat_q,
  input logic [NUM_SRC-1:0]   level_q,
  input logic [L2_W-1:0]      stat2_q
);
  // R5
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[0] |-> (serirq_o == '0));

  // R7
  summary_mode_no_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !routed_mode |-> (serirq_o == '0));

  // R8
  summary_tracks_l2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    summary_o == (stat2_q != '0));

  // R9
  noresp_sets_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    noresp_pulse |=> stat_q[NUM_SRC]);

  // R2
  rise_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_in & ~level_q) != '0) |=>
      ((stat_q[NUM_SRC-1:0] & $past(irq_in & ~level_q)) == $past(irq_in & ~level_q)));

  // R3
  held_bits_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q[NUM_SRC-1:0] & level_q & irq_in) != '0) |=>
      ((stat_q[NUM_SRC-1:0] & $past(stat_q[NUM_SRC-1:0] & level_q & irq_in))
        == $past(stat_q[NUM_SRC-1:0] & level_q & irq_in)));
endmodule

bind irq_agg_router irq_agg_router_chk #(
  .NUM_SRC(NUM_SRC), .NUM_LINES(NUM_LINES), .L2_W(L2_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .routed_mode  (routed_mode),
  .irq_in       (irq_in),
  .noresp_pulse (noresp_pulse),
  .serirq_o     (serirq_o),
  .summary_o    (summary_o),
  .ctrl_q       (ctrl_q),
  .stat_q       (stat_q),
  .level_q      (level_q),
  .stat2_q      (stat2_q)
);

// File: tb/tb_irq_agg_router.sv
module tb_irq_agg_router;
  localparam int NS = 16;
  localparam int NL = 4;

  logic clk = 1'b0, rst_n = 1'b0, routed_mode = 1'b1;
  logic [NS-1:0] irq_in = '0;
  logic noresp_pulse = 1'b0, reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [NL-1:0] serirq_o;
  logic summary_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // behavioural model state
  logic [1:0]  m_ctrl;
  logic [16:0] m_mask, m_stat;
  logic [31:0] m_ra, m_rb, m_pol;
  logic [7:0]  m_mask2, m_stat2, m_in2;
  logic [15:0] m_lvl;
  logic [3:0]  m_ser;
  logic        m_sum;

  irq_agg_router dut (
    .clk(clk), .rst_n(rst_n), .routed_mode(routed_mode), .irq_in(irq_in),
    .noresp_pulse(noresp_pulse), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .serirq_o(serirq_o),
    .summary_o(summary_o)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ctrl = '0; m_mask = '0; m_stat = '0; m_ra = '0; m_rb = '0; m_pol = '0;
    m_mask2 = '0; m_stat2 = '0; m_in2 = '0; m_lvl = '0; m_ser = '0; m_sum = 1'b0;
  endtask

  function automatic logic [31:0] model_read(input logic [3:0] a);
    case (a)
      4'd0: return 32'(m_ctrl);
      4'd1: return 32'(m_mask);
      4'd2: return 32'(m_stat);
      4'd3: return m_ra;
      4'd4: return m_rb;
      4'd5: return m_pol;
      4'd6: return 32'(m_mask2);
      4'd7: return 32'(m_stat2);
      4'd8: return 32'(m_lvl);
      4'd9: return 32'(m_in2);
      default: return 32'd0;
    endcase
  endfunction

  // one clock of the requirement model, from pre-edge state and inputs
  task automatic model_step();
    logic [15:0] rs, fl;
    logic [16:0] st, act;
    logic [63:0] rt;
    logic [7:0]  s2;
    logic        w;
    w  = reg_we;
    rs = irq_in & ~m_lvl;
    fl = ~irq_in & m_lvl;
    st = m_stat;
    if (w && reg_addr == 4'd2) st = st & ~(reg_wdata[16:0] & ~{1'b0, m_lvl});
    if (routed_mode && m_ctrl[1]) st = st & ~{1'b0, fl};
    st = st | {noresp_pulse, rs};
    if (w && reg_addr == 4'd0) m_ctrl  = reg_wdata[1:0];
    if (w && reg_addr == 4'd1) m_mask  = reg_wdata[16:0];
    if (w && reg_addr == 4'd3) m_ra    = reg_wdata;
    if (w && reg_addr == 4'd4) m_rb    = reg_wdata;
    if (w && reg_addr == 4'd5) m_pol   = reg_wdata;
    if (w && reg_addr == 4'd6) m_mask2 = reg_wdata[7:0];
    m_stat = st;
    m_lvl  = irq_in;
    act = st & m_mask;
    rt  = {m_rb, m_ra};
    m_ser = '0;
    if (m_ctrl[0] && routed_mode)
      for (int i = 0; i < 17; i++) if (act[i]) m_ser[rt[2*i +: 2]] = 1'b1;
    m_in2 = (m_ctrl[0] && !routed_mode && act != 0) ? 8'h01 : 8'h00;
    s2 = m_stat2;
    if (w && reg_addr == 4'd7) s2 = s2 & ~reg_wdata[7:0];
    m_stat2 = s2 | (m_in2 & m_mask2);
    m_sum = (m_stat2 != 0);
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    #1;
  endtask

  task automatic do_reset(input logic mode);
    rst_n = 1'b0; routed_mode = mode;
    reg_we = 1'b0; irq_in = '0; noresp_pulse = 1'b0;
    model_reset();
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [3:0] a, input logic [31:0] exp);
    reg_addr = a; #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic random_phase(input int cycles);
    for (int c = 0; c < cycles; c++) begin
      reg_we    = ($urandom % 4) == 0;
      reg_addr  = 4'($urandom % 11);
      reg_wdata = $urandom;
      for (int b = 0; b < NS; b++) if (($urandom % 12) == 0) irq_in[b] = ~irq_in[b];
      noresp_pulse = ($urandom % 40) == 0;
      #1;
      chk("R1/R2/R3/R4/R9/R11 read", reg_rdata, model_read(reg_addr));
      tick();
      chk("R5/R6/R7/R10 serirq", 32'(serirq_o), 32'(m_ser));
      chk("R8 summary", 32'(summary_o), 32'(m_sum));
    end
    reg_we = 1'b0; noresp_pulse = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    // routed mode, directed
    do_reset(1'b1);
    for (int a = 0; a < 16; a++) rd("R1 reset register", 4'(a), 32'd0);
    chk("R1 reset serirq", 32'(serirq_o), 32'd0);
    chk("R1 reset summary", 32'(summary_o), 32'd0);

    wr(4'd0, 32'h3); wr(4'd1, 32'h1FFFF); wr(4'd3, 32'h80);
    irq_in = 16'h0008; tick();
    rd("R2 status set on rise", 4'd2, 32'h8);
    rd("R2 level bit set", 4'd8, 32'h8);
    chk("R6 source3 to line2", 32'(serirq_o), 32'h4);
    wr(4'd2, 32'h8);
    rd("R3 held bit not cleared", 4'd2, 32'h8);
    irq_in = '0; tick();
    rd("R4 auto-clear on fall", 4'd2, 32'h0);
    rd("R2 level bit cleared", 4'd8, 32'h0);
    chk("R4 line drops", 32'(serirq_o), 32'h0);

    wr(4'd0, 32'h1);
    irq_in = 16'h0008; tick();
    irq_in = '0; tick();
    rd("R4 no auto-clear keeps status", 4'd2, 32'h8);
    chk("R6 line still high", 32'(serirq_o), 32'h4);
    wr(4'd2, 32'h8);
    rd("R3 write-one clears released bit", 4'd2, 32'h0);

    noresp_pulse = 1'b1; tick(); noresp_pulse = 1'b0;
    rd("R9 error bit set", 4'd2, 32'h10000);
    chk("R6 error bit to line0", 32'(serirq_o), 32'h1);
    reg_we = 1'b1; reg_addr = 4'd0; reg_wdata = 32'h0; #1;
    chk("R10 output unchanged before edge", 32'(serirq_o), 32'h1);
    tick(); reg_we = 1'b0;
    chk("R5 disable drops lines", 32'(serirq_o), 32'h0);
    rd("R5 status kept while disabled", 4'd2, 32'h10000);
    wr(4'd5, 32'hFFFF_FFFF);
    rd("R11 polarity readback", 4'd5, 32'hFFFF_FFFF);
    rd("R11 status unaffected", 4'd2, 32'h10000);
    chk("R11 lines unaffected", 32'(serirq_o), 32'h0);

    do_reset(1'b1);
    random_phase(2500);

    // summary mode, directed
    do_reset(1'b0);
    wr(4'd0, 32'h1); wr(4'd1, 32'h1FFFF); wr(4'd6, 32'h1); wr(4'd3, 32'hFFFF_FFFF);
    irq_in = 16'h0020; tick();
    chk("R7 no lines in summary mode", 32'(serirq_o), 32'h0);
    rd("R7 second-level input set", 4'd9, 32'h1);
    rd("R8 second-level status latched", 4'd7, 32'h1);
    chk("R8 summary high", 32'(summary_o), 32'h1);
    wr(4'd7, 32'h1);
    rd("R8 re-latch while cause present", 4'd7, 32'h1);
    irq_in = '0; tick();
    wr(4'd2, 32'h20);
    rd("R7 second-level input cleared", 4'd9, 32'h0);
    rd("R8 sticky after cause gone", 4'd7, 32'h1);
    chk("R8 summary still high", 32'(summary_o), 32'h1);
    wr(4'd7, 32'h1);
    rd("R8 write-one clears", 4'd7, 32'h0);
    chk("R8 summary low", 32'(summary_o), 32'h0);
    wr(4'd0, 32'h0);
    irq_in = 16'h0020; tick();
    rd("R5 no second-level input when disabled", 4'd9, 32'h0);
    chk("R5 summary stays low", 32'(summary_o), 32'h0);
    rd("R5 status still records", 4'd2, 32'h20);

    do_reset(1'b0);
    random_phase(2500);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule